// File: doc/BRIEF.md
# MDIO Management Frame Shifter

This block carries one station-management frame between a host and an Ethernet PHY over the two-wire MDC/MDIO bus. The host writes a 32-bit frame word, and that write also starts the transfer. The word sits in a single register that rotates left once per MDC period. The bit leaving the top is driven onto MDIO, and the bit entering the bottom comes from the line. After 32 rotations the word is back in its starting position, with the data field replaced by whatever the PHY returned.

MDC is made by dividing the system clock. The host picks the divisor with a two-bit selector, and the selector is captured when a transfer starts. While the frame is on the wire the host may read the register at any time and sees it partly rotated. When the frame ends, the idle flag returns to 1 and a one-cycle interrupt pulse is raised.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, idle is 1, irq is 0, mdc is 0, mdio_oe is 0 and rd_data is 0. Whenever the block is idle, mdc and mdio_oe stay 0.
- R2: A write accepted while idle drops idle to 0 on the next cycle. Idle returns to 1 exactly 32 bit periods after the accepting edge, and irq is 1 for that single cycle only.
- R3: Selector codes 0, 1, 2 and 3 give bit periods of 16, 32, 48 and 64 system clocks. MDC is low for the first half of each period and high for the second half. The selector is captured at the start of a transfer, so changing it mid-frame has no effect.
- R4: MDIO carries the register's bit 31. It changes only when MDC falls and holds steady while MDC is high. The line is sampled at the MDC rising edge.
- R5: After n completed bit periods of a write frame, rd_data equals the original word rotated left by n.
- R6: A write frame (bits [29:28] = 01) keeps mdio_oe at 1 for the whole frame. With the bus looped back, the word ends identical to the word written.
- R7: A read frame (bits [29:28] = 10) keeps mdio_oe at 1 for the first 14 bits. It drops mdio_oe to 0 from the first turnaround bit (bit 17) to the end. The PHY bits sampled during the last 16 periods fill bits [15:0], the first one landing in bit 15, and bits [31:16] end unchanged.
- R8: A write that arrives while a frame is in progress is ignored. Neither the register contents nor the timing of the current frame change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the frame register |
| wr_data | input | 32 | Frame word to send |
| rd_data | output | 32 | Live contents of the frame register |
| div_sel | input | 2 | MDC divisor selector |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Sampled MDIO line |
| idle | output | 1 | 1 when no frame is in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second write, combined with a divisor change, that lands in the middle of a running frame. Nothing in the outcome shows that the write was dropped, other than the final word and the exact finish cycle. The bench writes a frame at the fastest divisor and waits three bit periods. It then writes a different word while switching the selector to its slowest code. It checks that idle rises on the cycle set by the first divisor and that the first word comes back intact. A looped-back bus model with a PHY that drives only while output enable is low lets the same bench show both the in-place rotation and the capture of read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      MOP_RSVD0 = 2'b00,
      MOP_WRITE = 2'b01,
      MOP_READ  = 2'b10,
      MOP_RSVD3 = 2'b11
   } mgmt_op_e;

   localparam int unsigned OP_MSB = 29;
   localparam int unsigned OP_LSB = 28;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int unsigned DIV_BASE = 16,
   parameter int unsigned SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [SEL_W-1:0] div_sel,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   localparam int unsigned NUM_CODES = 1 << SEL_W;
   localparam int unsigned MAX_DIV   = DIV_BASE * NUM_CODES;
   localparam int unsigned CNT_W     = $clog2(MAX_DIV + 1);

   if ((DIV_BASE % 2) != 0 || DIV_BASE < 4) begin : g_bad_base
      $error("DIV_BASE must be even and at least 4");
   end

   logic [CNT_W-1:0] div_lut [NUM_CODES];
   for (genvar g = 0; g < NUM_CODES; g++) begin : g_lut
      assign div_lut[g] = CNT_W'(DIV_BASE * (g + 1));
   end

   logic [CNT_W-1:0] period_q, cnt_q;
   logic             mdc_q;
   logic [CNT_W-1:0] half;

   assign half     = period_q >> 1;
   assign rise_stb = run && !start && (cnt_q == half - 1'b1);
   assign fall_stb = run && !start && (cnt_q == period_q - 1'b1);
   assign mdc      = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= div_lut[1 % NUM_CODES];
         cnt_q    <= '0;
         mdc_q    <= 1'b0;
      end else if (start) begin
         period_q <= div_lut[div_sel];
         cnt_q    <= '0;
         mdc_q    <= 1'b0;
      end else if (run) begin
         if (fall_stb) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (rise_stb) mdc_q <= 1'b1;
         end
      end
   end

   assert_mdc_rise_at_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $past(cnt_q) == $past(half) - 1'b1);
   assert_period_fixed_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run && !start |=> $stable(period_q));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
   parameter int unsigned FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               rise_stb,
   input  logic               fall_stb,
   input  logic               take_line,
   input  logic               mdio_i,
   output logic [FRAME_W-1:0] frame_q
);
   if (FRAME_W < 8) begin : g_bad_w
      $error("FRAME_W too small");
   end

   logic smp_q;
   logic fill_bit;

   assign fill_bit = take_line ? smp_q : frame_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q   <= 1'b0;
         frame_q <= '0;
      end else begin
         if (rise_stb) smp_q <= mdio_i;
         if (load)
            frame_q <= load_val;
         else if (fall_stb)
            frame_q <= {frame_q[FRAME_W-2:0], fill_bit};
      end
   end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
#(
   parameter int unsigned FRAME_W = 32,
   parameter int unsigned DATA_W  = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  mgmt_op_e wr_op,
   input  logic     fall_stb,
   output logic     busy,
   output logic     start,
   output logic     take_line,
   output logic     oe,
   output logic     irq
);
   localparam int unsigned CNT_W      = $clog2(FRAME_W);
   localparam int unsigned DATA_SHIFT = FRAME_W - DATA_W;
   localparam int unsigned TA_SHIFT   = DATA_SHIFT - 2;

   if (DATA_W + 4 > FRAME_W) begin : g_bad_data
      $error("DATA_W leaves no room for header bits");
   end

   logic             busy_q, is_read_q, irq_q;
   logic [CNT_W-1:0] count_q;
   logic             last;

   assign start     = wr_en && !busy_q;
   assign last      = fall_stb && (count_q == CNT_W'(FRAME_W - 1));
   assign take_line = count_q >= CNT_W'(DATA_SHIFT);
   assign oe        = busy_q && !(is_read_q && (count_q >= CNT_W'(TA_SHIFT)));
   assign busy      = busy_q;
   assign irq       = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         is_read_q <= 1'b0;
         irq_q     <= 1'b0;
         count_q   <= '0;
      end else begin
         irq_q <= last;
         if (start) begin
            busy_q    <= 1'b1;
            is_read_q <= (wr_op == MOP_READ);
            count_q   <= '0;
         end else if (fall_stb) begin
            count_q <= count_q + 1'b1;
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assert_oe_release_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) && busy_q |-> is_read_q);
   assert_irq_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter int unsigned FRAME_W  = 32,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned DIV_BASE = 16,
   parameter int unsigned SEL_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FRAME_W-1:0] wr_data,
   output logic [FRAME_W-1:0] rd_data,
   input  logic [SEL_W-1:0]   div_sel,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic               mdio_i,
   output logic               idle,
   output logic               irq
);
   if (FRAME_W <= OP_MSB) begin : g_bad_frame
      $error("FRAME_W must hold the op field");
   end

   logic busy, start, take_line, rise_stb, fall_stb;
   logic [FRAME_W-1:0] frame_q;

   mdio_clkdiv #(.DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
      .div_sel(div_sel), .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_seq #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_op(mgmt_op_e'(wr_data[OP_MSB:OP_LSB])), .fall_stb(fall_stb),
      .busy(busy), .start(start), .take_line(take_line), .oe(mdio_oe), .irq(irq)
   );

   mdio_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(wr_data),
      .rise_stb(rise_stb), .fall_stb(fall_stb), .take_line(take_line),
      .mdio_i(mdio_i), .frame_q(frame_q)
   );

   assign rd_data = frame_q;
   assign mdio_o  = busy & frame_q[FRAME_W-1];
   assign idle    = !busy;

   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mdc && !mdio_oe);
   assert_irq_at_idle_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> idle && !$past(idle));
   assert_idle_falls_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle) |-> $past(wr_en));
   assert_mdio_held_while_mdc_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mdc && $past(mdc) |-> $stable(mdio_o));
   assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !idle && wr_en && !fall_stb |=> rd_data == $past(rd_data));
endmodule

// File: tb/tb_mdio_frame_engine.sv
module tb_mdio_frame_engine;
   typedef struct packed {
      logic [1:0]  code;
      logic [31:0] frame;
      logic [15:0] phy;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 32'h5182_A5C3, 16'h0000, 32'h5182_A5C3},
      '{2'd1, 32'h6F8B_0000, 16'hBEEF, 32'h6F8B_BEEF},
      '{2'd2, 32'h6F8B_FFFF, 16'h0000, 32'h6F8B_0000},
      '{2'd3, 32'h5FFE_0001, 16'hFFFF, 32'h5FFE_0001},
      '{2'd1, 32'h6F8B_1111, 16'h8001, 32'h6F8B_8001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  div_sel = 2'd1;
   logic        mdc, mdio_o, mdio_oe, mdio_i, idle, irq;
   logic [15:0] phy_data = '0;
   logic [4:0]  phy_cnt;
   logic [4:0]  phy_idx;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   mdio_frame_engine dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .div_sel(div_sel), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i), .idle(idle), .irq(irq)
   );

   always @(posedge mdc or negedge rst_n) begin
      if (!rst_n) phy_cnt <= '0;
      else        phy_cnt <= phy_cnt + 1'b1;
   end
   assign phy_idx = 5'd31 - phy_cnt;
   assign mdio_i  = mdio_oe ? mdio_o : (phy_cnt >= 5'd16 ? phy_data[phy_idx[3:0]] : 1'b1);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   task automatic host_write(input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      int dv, hf;
      bit is_wr;
      dv = 16 * (int'(v.code) + 1);
      hf = dv / 2;
      is_wr = (v.frame[29:28] == 2'b01);
      div_sel = v.code;
      phy_data = v.phy;
      host_write(v.frame);
      repeat (5 * dv) @(negedge clk);
      chk("R2 busy mid-frame", {31'd0, idle}, 32'd0);
      chk("R6/R7 oe early", {31'd0, mdio_oe}, 32'd1);
      chk("R4 mdio bit26", {31'd0, mdio_o}, {31'd0, v.frame[26]});
      repeat (hf - 1) @(negedge clk);
      chk("R3 mdc low first half", {31'd0, mdc}, 32'd0);
      @(negedge clk);
      chk("R3 mdc high second half", {31'd0, mdc}, 32'd1);
      repeat (15 * dv - hf) @(negedge clk);
      if (is_wr) begin
         chk("R5 live rotation n=20", rd_data, rotl(v.frame, 20));
         chk("R6 oe held on write", {31'd0, mdio_oe}, 32'd1);
         chk("R4 mdio bit11", {31'd0, mdio_o}, {31'd0, v.frame[11]});
      end else begin
         chk("R7 oe released on read", {31'd0, mdio_oe}, 32'd0);
      end
      repeat (12 * dv - 1) @(negedge clk);
      chk("R2 still busy last cycle", {31'd0, idle}, 32'd0);
      @(negedge clk);
      chk("R2 idle at end", {31'd0, idle}, 32'd1);
      chk("R2 irq at end", {31'd0, irq}, 32'd1);
      chk(is_wr ? "R6 word restored" : "R7 read data captured", rd_data, v.exp);
      @(negedge clk);
      chk("R2 irq one cycle", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset idle", {31'd0, idle}, 32'd1);
      chk("R1 reset irq", {31'd0, irq}, 32'd0);
      chk("R1 reset mdc/oe", {30'd0, mdc, mdio_oe}, 32'd0);
      chk("R1 reset rd_data", rd_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R8 and R3: write and divisor change mid-frame are ignored
      div_sel = 2'd0;
      host_write(32'h5182_A5C3);
      repeat (48) @(negedge clk);
      wr_en = 1'b1;
      wr_data = 32'h6000_0000;
      div_sel = 2'd3;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8 still busy after extra write", {31'd0, idle}, 32'd0);
      chk("R8 no reload", rd_data, rotl(32'h5182_A5C3, 3));
      repeat (462) @(negedge clk);
      chk("R3 latched divisor timing", {31'd0, idle}, 32'd0);
      @(negedge clk);
      chk("R8 idle on original schedule", {31'd0, idle}, 32'd1);
      chk("R8 original word kept", rd_data, 32'h5182_A5C3);
      @(negedge clk);
      chk("R1 quiet after frame", {30'd0, mdc, mdio_oe}, 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule